// File: doc/BRIEF.md
# Signal Activity Statistics Monitor

The block observes a vector of on-chip signals and, for each of them, gathers the two raw numbers from which signal probability and transition density are later derived. For each line it counts the sampled cycles in which the line is high, and the sampled cycles in which the line holds a different value from the sample just before. Every line is sampled in the same cycles. The fractions are formed outside the block by dividing by the run length times the run count.

A measurement is a sequence of back-to-back runs of equal length. A start strobe fixes the run length and run count, clears all accumulators and begins sampling. The totals grow across every run. When the last sample of the last run has been taken, the block returns to idle and pulses a done flag. While the block is idle, software or a neighbouring engine reads one line's totals at a time through an index-addressed read port.

Top module: `sigact_monitor`

## Requirements
- R1: After reset the block is idle (`busy_o`=0, `done_o`=0, `rd_valid_o`=1) and every line reads zero for both totals.
- R2: An accepted start samples `sig_i` on the `run_len_i`×`run_cnt_i` rising edges that follow the accepting edge. The high total of line i is the number of those samples in which bit i is 1.
- R3: The toggle total of line i counts the samples in which bit i differs from the previous sample of the same run. The first sample of each run is never counted, so one run adds at most `run_len_i`−1.
- R4: All lines are sampled on the same edges, and each line's totals depend only on its own bit.
- R5: Totals accumulate over all runs of a measurement. The run count field holds up to 16383 runs, and totals do not overflow for any allowed length and count.
- R6: `busy_o` is 1 from the edge that accepts a start through the edge of the last sample. At that edge `busy_o` falls and `done_o` goes high for exactly one cycle.
- R7: An accepted start clears both totals of every line before the first sample is added.
- R8: A start strobe while `busy_o`=1 is ignored. The run length, run count, totals and end time of the measurement in progress are unchanged.
- R9: A start strobe with `run_len_i`=0 or `run_cnt_i`=0 is ignored. The block stays idle and the totals keep their previous values.
- R10: While idle, `rd_valid_o`=1 and `rd_high_o`/`rd_tog_o` show the totals of line `rd_idx_i` in the same cycle. An index of NUM_SIG or above reads zero. While busy, `rd_valid_o`=0 and both read outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_i | input | NUM_SIG | Monitored signal vector |
| start_i | input | 1 | Start strobe; accepted only when idle with non-zero length and count |
| run_len_i | input | RUN_LEN_W | Cycles per run, latched on start |
| run_cnt_i | input | RUN_CNT_W | Number of runs, latched on start |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle pulse at the end of the last run |
| rd_idx_i | input | IDX_W | Line index for the read port |
| rd_valid_o | output | 1 | Read data is meaningful (block idle) |
| rd_high_o | output | ACC_W | High-cycle total of the addressed line |
| rd_tog_o | output | ACC_W | Toggle total of the addressed line |

## Verification
A wrong position or run counter shows as a `done_o` pulse at the wrong edge. A measurement of length L×N therefore lets the bench detect an off-by-one in the sequencer at the exact end cycle. A fault in one line's accumulator, or a toggle counted across a run boundary, stays hidden until the block is idle again. It then appears in the read-port totals, which differ from the bench's model by at least one count. Runs of constant, alternating and walking-one patterns make the expected totals large and exact, so a miscounted boundary is always visible.

// File: rtl/sigact_pkg.sv
package sigact_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    function automatic int unsigned acc_width(input int unsigned len_w, input int unsigned cnt_w);
        return len_w + cnt_w;
    endfunction
endpackage

// File: rtl/sigact_seq.sv
module sigact_seq
    import sigact_pkg::*;
#(
    parameter int unsigned RUN_LEN_W = 16,
    parameter int unsigned RUN_CNT_W = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [RUN_LEN_W-1:0] run_len_i,
    input  logic [RUN_CNT_W-1:0] run_cnt_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 clear_o,
    output logic                 sample_o,
    output logic                 first_o
);
    typedef struct packed {
        phase_e                 phase;
        logic                   done;
        logic [RUN_LEN_W-1:0]   pos;
        logic [RUN_CNT_W-1:0]   run;
        logic [RUN_LEN_W-1:0]   len;
        logic [RUN_CNT_W-1:0]   cnt;
    } seq_t;

    seq_t st_d, st_q;
    logic accept;
    logic last_pos;
    logic last_run;

    always_comb begin
        st_d     = st_q;
        st_d.done = 1'b0;
        accept   = (st_q.phase == PH_IDLE) && start_i &&
                   (run_len_i != '0) && (run_cnt_i != '0);
        last_pos = (st_q.pos == st_q.len - RUN_LEN_W'(1));
        last_run = (st_q.run == st_q.cnt - RUN_CNT_W'(1));
        unique case (st_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    st_d.phase = PH_RUN;
                    st_d.pos   = '0;
                    st_d.run   = '0;
                    st_d.len   = run_len_i;
                    st_d.cnt   = run_cnt_i;
                end
            end
            PH_RUN: begin
                if (last_pos) begin
                    st_d.pos = '0;
                    if (last_run) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.run = st_q.run + RUN_CNT_W'(1);
                    end
                end else begin
                    st_d.pos = st_q.pos + RUN_LEN_W'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, done: 1'b0, pos: '0, run: '0, len: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = (st_q.phase == PH_RUN);
    assign done_o   = st_q.done;
    assign clear_o  = accept;
    assign sample_o = busy_o;
    assign first_o  = busy_o && (st_q.pos == '0);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    // R8
    busy_start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(st_q.len) && $stable(st_q.cnt)));
    // R2
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ((st_q.pos < st_q.len) && (st_q.run < st_q.cnt)));
    // R9
    zero_param_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && ((run_len_i == '0) || (run_cnt_i == '0))) |=> !busy_o);
endmodule

// File: rtl/sigact_lane.sv
module sigact_lane #(
    parameter int unsigned ACC_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             sample_i,
    input  logic             first_i,
    input  logic             sig_i,
    output logic [ACC_W-1:0] high_o,
    output logic [ACC_W-1:0] tog_o
);
    typedef struct packed {
        logic [ACC_W-1:0] high;
        logic [ACC_W-1:0] tog;
        logic             prev;
    } lane_t;

    lane_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        if (clear_i) begin
            ln_d.high = '0;
            ln_d.tog  = '0;
        end else if (sample_i) begin
            ln_d.high = ln_q.high + {{(ACC_W-1){1'b0}}, sig_i};
            if (!first_i && (sig_i != ln_q.prev)) begin
                ln_d.tog = ln_q.tog + ACC_W'(1);
            end
            ln_d.prev = sig_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign high_o = ln_q.high;
    assign tog_o  = ln_q.tog;

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> ((high_o == '0) && (tog_o == '0)));
    // R2
    high_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((high_o == $past(high_o)) || (high_o == $past(high_o) + ACC_W'(1))));
    // R3
    first_no_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && first_i && !clear_i) |=> (tog_o == $past(tog_o)));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_i && !clear_i) |=> ($stable(high_o) && $stable(tog_o)));
endmodule

// File: rtl/sigact_rdmux.sv
module sigact_rdmux #(
    parameter int unsigned NUM_SIG = 8,
    parameter int unsigned ACC_W   = 30,
    parameter int unsigned IDX_W   = 4
) (
    input  logic                           busy_i,
    input  logic [NUM_SIG-1:0][ACC_W-1:0]  high_i,
    input  logic [NUM_SIG-1:0][ACC_W-1:0]  tog_i,
    input  logic [IDX_W-1:0]               idx_i,
    output logic                           valid_o,
    output logic [ACC_W-1:0]               high_o,
    output logic [ACC_W-1:0]               tog_o
);
    logic [NUM_SIG-1:0] hit;

    for (genvar g = 0; g < NUM_SIG; g++) begin : g_hit
        assign hit[g] = (idx_i == IDX_W'(g));
    end

    always_comb begin
        high_o = '0;
        tog_o  = '0;
        if (!busy_i) begin
            for (int i = 0; i < NUM_SIG; i++) begin
                if (hit[i]) begin
                    high_o = high_i[i];
                    tog_o  = tog_i[i];
                end
            end
        end
    end

    assign valid_o = !busy_i;
endmodule

// File: rtl/sigact_monitor.sv
module sigact_monitor
    import sigact_pkg::*;
#(
    parameter int unsigned NUM_SIG   = 8,
    parameter int unsigned RUN_LEN_W = 16,
    parameter int unsigned RUN_CNT_W = 14,
    localparam int unsigned ACC_W    = acc_width(RUN_LEN_W, RUN_CNT_W),
    localparam int unsigned IDX_W    = $clog2(NUM_SIG) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SIG-1:0]   sig_i,
    input  logic                 start_i,
    input  logic [RUN_LEN_W-1:0] run_len_i,
    input  logic [RUN_CNT_W-1:0] run_cnt_i,
    output logic                 busy_o,
    output logic                 done_o,
    input  logic [IDX_W-1:0]     rd_idx_i,
    output logic                 rd_valid_o,
    output logic [ACC_W-1:0]     rd_high_o,
    output logic [ACC_W-1:0]     rd_tog_o
);
    logic clear;
    logic sample;
    logic first;
    logic [NUM_SIG-1:0][ACC_W-1:0] high_all;
    logic [NUM_SIG-1:0][ACC_W-1:0] tog_all;

    sigact_seq #(
        .RUN_LEN_W (RUN_LEN_W),
        .RUN_CNT_W (RUN_CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .run_len_i (run_len_i),
        .run_cnt_i (run_cnt_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .clear_o   (clear),
        .sample_o  (sample),
        .first_o   (first)
    );

    for (genvar g = 0; g < NUM_SIG; g++) begin : g_lane
        sigact_lane #(
            .ACC_W (ACC_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (clear),
            .sample_i (sample),
            .first_i  (first),
            .sig_i    (sig_i[g]),
            .high_o   (high_all[g]),
            .tog_o    (tog_all[g])
        );
    end

    sigact_rdmux #(
        .NUM_SIG (NUM_SIG),
        .ACC_W   (ACC_W),
        .IDX_W   (IDX_W)
    ) u_rd (
        .busy_i  (busy_o),
        .high_i  (high_all),
        .tog_i   (tog_all),
        .idx_i   (rd_idx_i),
        .valid_o (rd_valid_o),
        .high_o  (rd_high_o),
        .tog_o   (rd_tog_o)
    );
endmodule

// File: tb/sigact_monitor_bench.sv
module sigact_monitor_bench;
    localparam int NUM_SIG   = 8;
    localparam int RUN_LEN_W = 16;
    localparam int RUN_CNT_W = 14;
    localparam int ACC_W     = RUN_LEN_W + RUN_CNT_W;
    localparam int IDX_W     = $clog2(NUM_SIG) + 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NUM_SIG-1:0]   sig = '0;
    logic                 start = 1'b0;
    logic [RUN_LEN_W-1:0] run_len = '0;
    logic [RUN_CNT_W-1:0] run_cnt = '0;
    logic                 busy, done, rd_valid;
    logic [IDX_W-1:0]     rd_idx = '0;
    logic [ACC_W-1:0]     rd_high, rd_tog;

    int n_chk = 0;
    int n_bad = 0;
    int exp_high [NUM_SIG];
    int exp_tog  [NUM_SIG];
    logic [NUM_SIG-1:0] prev_v;

    always #2 clk = ~clk;

    sigact_monitor #(
        .NUM_SIG (NUM_SIG), .RUN_LEN_W (RUN_LEN_W), .RUN_CNT_W (RUN_CNT_W)
    ) u_sigact_monitor (
        .clk (clk), .rst_n (rst_n), .sig_i (sig), .start_i (start),
        .run_len_i (run_len), .run_cnt_i (run_cnt), .busy_o (busy), .done_o (done),
        .rd_idx_i (rd_idx), .rd_valid_o (rd_valid), .rd_high_o (rd_high), .rd_tog_o (rd_tog)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [NUM_SIG-1:0] gen_vec(input int mode, input int k);
        case (mode)
            1:       return '1;
            2:       return (k % 2 == 1) ? NUM_SIG'('hAA) : NUM_SIG'('h55);
            3:       return NUM_SIG'(1) << (k % NUM_SIG);
            default: return NUM_SIG'($urandom);
        endcase
    endfunction

    function automatic int bit_diff(input logic a, input logic b);
        return (a != b) ? 1 : 0;
    endfunction

    task automatic read_all(input string req);
        for (int i = 0; i < NUM_SIG; i++) begin
            @(negedge clk);
            rd_idx = IDX_W'(i);
            #1;
            check({req, " high"}, int'(rd_high), exp_high[i]);
            check({req, " tog"},  int'(rd_tog),  exp_tog[i]);
        end
    endtask

    task automatic do_run(input int len, input int cnt, input int mode, input int glitch_k, input string req);
        int total;
        logic [NUM_SIG-1:0] v;
        total = len * cnt;
        for (int i = 0; i < NUM_SIG; i++) begin exp_high[i] = 0; exp_tog[i] = 0; end
        @(negedge clk);
        start = 1'b1; run_len = RUN_LEN_W'(len); run_cnt = RUN_CNT_W'(cnt);
        for (int k = 0; k < total; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (k == 0) check("R6 busy after start", int'(busy), 1);
            if (k == glitch_k) begin
                start = 1'b1; run_len = RUN_LEN_W'(len + 3); run_cnt = RUN_CNT_W'(cnt + 1);
            end
            v = gen_vec(mode, k);
            sig = v;
            for (int i = 0; i < NUM_SIG; i++) begin
                exp_high[i] += int'(v[i]);
                if (k % len != 0) exp_tog[i] += bit_diff(v[i], prev_v[i]);
            end
            prev_v = v;
            if (k == total - 1) begin
                check("R6 busy before last edge", int'(busy), 1);
                check("R6 no early done", int'(done), 0);
                check("R10 read gated while busy", int'(rd_valid) + int'(rd_high) + int'(rd_tog), 0);
            end
        end
        @(negedge clk);
        start = 1'b0;
        check("R6 done at end", int'(done), 1);
        check("R6 busy falls", int'(busy), 0);
        @(negedge clk);
        check("R6 done one cycle", int'(done), 0);
        check("R10 valid when idle", int'(rd_valid), 1);
        read_all(req);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        prev_v = '0;
        for (int i = 0; i < NUM_SIG; i++) begin exp_high[i] = 0; exp_tog[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 valid", int'(rd_valid), 1);
        read_all("R1 reset totals");

        do_run(5, 3, 0, -1, "R2 R3 R4 random");
        do_run(48, 4, 0, -1, "R2 R5 default length");
        do_run(7, 3, 1, -1, "R3 constant high");
        do_run(6, 4, 2, -1, "R3 alternating run boundary");
        do_run(9, 2, 3, -1, "R4 walking one");
        do_run(1, 5, 2, -1, "R3 single-cycle run");
        do_run(10, 3, 0, 4, "R8 start while busy");
        do_run(4, 2, 1, -1, "R7 clear before reuse");

        // R9: zero length, then zero count; totals keep the last measurement
        @(negedge clk); start = 1'b1; run_len = '0; run_cnt = 14'd3;
        @(negedge clk); start = 1'b0;
        check("R9 zero length ignored", int'(busy), 0);
        @(negedge clk); start = 1'b1; run_len = 16'd5; run_cnt = '0;
        @(negedge clk); start = 1'b0;
        check("R9 zero count ignored", int'(busy), 0);
        read_all("R9 totals kept");

        // R10: index beyond the last line
        @(negedge clk); rd_idx = IDX_W'(NUM_SIG); #1;
        check("R10 out of range high", int'(rd_high), 0);
        check("R10 out of range tog", int'(rd_tog), 0);

        // R5: many runs
        do_run(1, 10000, 1, -1, "R5 ten thousand runs");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule